// File: doc/BRIEF.md
# Timer-Paced Parallel ADC Sample Capture Controller

This block runs an external parallel-output analog-to-digital converter at a fixed sampling rate. An internal interval timer fires once every programmed number of clock cycles. On each firing, while the converter is idle, the block drives a start pulse of fixed width. The falling edge of that pulse begins the conversion and puts the converter's track-and-hold into hold. The block then watches the converter's active-low busy line through a synchronizer.

When busy returns high, the conversion is complete and the block raises its interrupt flag. In the same cycle it pulls chip-select and read low together for a programmed number of cycles. On the last of those cycles it captures the 8-bit data bus into a 16-entry FIFO. The host drains that FIFO in batches whenever it chooses.

Two rules protect the sampling instants. The block never issues a read strobe while a conversion is running, and it never issues a second start pulse before the current conversion has been read out. A timer firing that lands inside a busy window is skipped, and a sticky overrun flag records that it happened.

Top module: `adc_pace_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the outputs are as follows: `adc_st` is 0, `adc_cs_n` and `adc_rd_n` are 1, `irq` is 0, `fifo_empty` is 1, `fifo_full` is 0, `fifo_level` is 0, `overrun` is 0 and `drop_count` is 0.
- R2: With `enable` high and the controller idle, `adc_st` rises exactly once every `period_cfg` clock cycles and stays high for ST_CYCLES cycles (default 2).
- R3: `adc_st` is never raised while a conversion is in flight, meaning from a start pulse until its result has been read. A timer firing during that window starts nothing.
- R4: `adc_cs_n` and `adc_rd_n` are always equal. After busy returns high they go low together for `rd_len_cfg` cycles, with a value of 0 treated as 1. They are never low while `adc_busy_n` is low or while `adc_st` is high.
- R5: The value on `adc_data` during the last strobe cycle is written to the FIFO. Samples leave the FIFO in conversion order.
- R6: `irq` rises in the same cycle that the strobe goes low, and clears in the cycle that `adc_cs_n`/`adc_rd_n` return high.
- R7: The FIFO holds 16 samples. `rd_data` always shows the oldest sample, and a `pop` removes it. `fifo_level` gives the count, `fifo_full` is set at 16 and `fifo_empty` is set at 0.
- R8: A sample that arrives while the FIFO is full is discarded, and `drop_count` increments. The counter saturates at 255.
- R9: A `pop` while the FIFO is empty has no effect: the level stays 0 and `fifo_empty` stays 1.
- R10: `overrun` is set when a timer firing is skipped under R3, and it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the interval timer |
| period_cfg | input | 16 | Sample period in clock cycles |
| rd_len_cfg | input | 4 | Strobe width in cycles (0 treated as 1) |
| adc_busy_n | input | 1 | Converter busy, low during conversion |
| adc_data | input | 8 | Converter data bus |
| adc_st | output | 1 | Conversion start pulse; conversion begins on its falling edge |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| irq | output | 1 | Result-ready flag |
| pop | input | 1 | Removes the oldest FIFO sample |
| rd_data | output | 8 | Oldest FIFO sample |
| fifo_empty | output | 1 | FIFO holds no samples |
| fifo_full | output | 1 | FIFO holds 16 samples |
| fifo_level | output | 5 | Number of samples held |
| overrun | output | 1 | Sticky flag for a skipped timer firing |
| drop_count | output | 8 | Samples discarded while the FIFO was full |

## Verification
If the sequencer state is corrupted, the ports show it within one conversion. A strobe appears while busy is low, a start pulse lands inside a conversion, `irq` stops tracking the strobe, or the spacing between start pulses drifts from `period_cfg`. The bench's converter model flags each of these on the cycle it happens. A wrong FIFO pointer or level appears as soon as the host drains a batch: the popped values come out of order or repeated, or the level, full flag and drop count disagree with the number of conversions the model completed.

// File: rtl/adc_pace_pkg.sv
package adc_pace_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_START,
    SQ_ARM,
    SQ_CONV,
    SQ_READ
  } seq_state_t;
endpackage

// File: rtl/pace_timer.sv
module pace_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period_cfg,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last = (period_cfg == '0) ? '0 : period_cfg - 1'b1;
    tick = en && (cnt_q == last);
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/busy_sync.sv
module busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import adc_pace_pkg::*;
#(
  parameter int ST_CYCLES = 2,
  parameter int STRB_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              busy_n_s,
  input  logic [STRB_W-1:0] rd_len_cfg,
  output logic              st,
  output logic              strobe_n,
  output logic              irq,
  output logic              push,
  output logic              overrun
);
  localparam int ST_W  = $clog2(ST_CYCLES + 1);
  localparam int CNT_W = (STRB_W > ST_W) ? STRB_W : ST_W;
  localparam logic [CNT_W-1:0] ST_LAST = CNT_W'(ST_CYCLES - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, rd_last;
  logic             irq_q, irq_d, ovr_q, ovr_d;

  always_comb begin
    rd_last  = (rd_len_cfg == '0) ? '0 : CNT_W'(rd_len_cfg - 1'b1);
    state_d  = state_q;
    cnt_d    = cnt_q;
    irq_d    = irq_q;
    ovr_d    = ovr_q;
    push     = 1'b0;
    if (tick && (state_q != SQ_IDLE)) ovr_d = 1'b1;
    case (state_q)
      SQ_IDLE: if (tick) begin
        state_d = SQ_START;
        cnt_d   = '0;
      end
      SQ_START: begin
        if (cnt_q == ST_LAST) state_d = SQ_ARM;
        else                  cnt_d   = cnt_q + 1'b1;
      end
      SQ_ARM:  if (!busy_n_s) state_d = SQ_CONV;
      SQ_CONV: if (busy_n_s) begin
        state_d = SQ_READ;
        cnt_d   = '0;
        irq_d   = 1'b1;
      end
      SQ_READ: begin
        if (cnt_q == rd_last) begin
          push    = 1'b1;
          irq_d   = 1'b0;
          state_d = SQ_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      irq_q   <= irq_d;
      ovr_q   <= ovr_d;
    end
  end

  assign st       = (state_q == SQ_START);
  assign strobe_n = (state_q != SQ_READ);
  assign irq      = irq_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int DROP_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  output logic [DW-1:0]             rd_data,
  output logic                      empty,
  output logic                      full,
  output logic [$clog2(DEPTH):0]    level,
  output logic [DROP_W-1:0]         drop_count
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [DW-1:0]     mem_q [DEPTH];
  logic [AW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0]     lvl_q, lvl_d;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              do_push, do_pop;

  always_comb begin
    empty   = (lvl_q == '0);
    full    = (lvl_q == LW'(DEPTH));
    do_push = push && !full;
    do_pop  = pop && !empty;
    wr_d    = wr_q;
    rd_d    = rd_q;
    lvl_d   = lvl_q;
    drop_d  = drop_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      lvl_d = lvl_q + 1'b1;
    else if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
    if (push && full && (drop_q != '1)) drop_d = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      lvl_q  <= '0;
      drop_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      lvl_q  <= lvl_d;
      drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  assign rd_data    = mem_q[rd_q];
  assign level      = lvl_q;
  assign drop_count = drop_q;
endmodule

// File: rtl/adc_pace_ctrl.sv
module adc_pace_ctrl #(
  parameter int PERIOD_W    = 16,
  parameter int STRB_W      = 4,
  parameter int DW          = 8,
  parameter int DEPTH       = 16,
  parameter int DROP_W      = 8,
  parameter int ST_CYCLES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [PERIOD_W-1:0]     period_cfg,
  input  logic [STRB_W-1:0]       rd_len_cfg,
  input  logic                    adc_busy_n,
  input  logic [DW-1:0]           adc_data,
  output logic                    adc_st,
  output logic                    adc_cs_n,
  output logic                    adc_rd_n,
  output logic                    irq,
  input  logic                    pop,
  output logic [DW-1:0]           rd_data,
  output logic                    fifo_empty,
  output logic                    fifo_full,
  output logic [$clog2(DEPTH):0]  fifo_level,
  output logic                    overrun,
  output logic [DROP_W-1:0]       drop_count
);
  logic tick, busy_n_s, strobe_n, push;

  pace_timer #(.PERIOD_W(PERIOD_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .en(enable), .period_cfg(period_cfg), .tick(tick)
  );

  busy_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(adc_busy_n), .dout(busy_n_s)
  );

  conv_seq #(.ST_CYCLES(ST_CYCLES), .STRB_W(STRB_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busy_n_s(busy_n_s),
    .rd_len_cfg(rd_len_cfg), .st(adc_st), .strobe_n(strobe_n),
    .irq(irq), .push(push), .overrun(overrun)
  );

  sample_fifo #(.DW(DW), .DEPTH(DEPTH), .DROP_W(DROP_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(adc_data), .pop(pop),
    .rd_data(rd_data), .empty(fifo_empty), .full(fifo_full),
    .level(fifo_level), .drop_count(drop_count)
  );

  assign adc_cs_n = strobe_n;
  assign adc_rd_n = strobe_n;
endmodule

// File: rtl/adc_pace_ctrl_chk.sv
module adc_pace_ctrl_chk #(
  parameter int DEPTH  = 16,
  parameter int DROP_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   adc_busy_n,
  input logic                   adc_st,
  input logic                   adc_cs_n,
  input logic                   adc_rd_n,
  input logic                   irq,
  input logic                   fifo_empty,
  input logic                   fifo_full,
  input logic [$clog2(DEPTH):0] fifo_level,
  input logic                   overrun,
  input logic [DROP_W-1:0]      drop_count
);
  AST_ST_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_st |-> adc_busy_n); // R3
  AST_NO_READ_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rd_n |-> (adc_busy_n && !adc_st)); // R4
  AST_STROBE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n == adc_rd_n); // R4
  AST_IRQ_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> !irq); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty)); // R7
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= ($clog2(DEPTH) + 1)'(DEPTH)); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R10
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> $past(fifo_full)); // R8
endmodule

bind adc_pace_ctrl adc_pace_ctrl_chk #(.DEPTH(DEPTH), .DROP_W(DROP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .adc_busy_n(adc_busy_n), .adc_st(adc_st),
  .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .irq(irq),
  .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_level(fifo_level),
  .overrun(overrun), .drop_count(drop_count)
);

// File: tb/adc_pace_ctrl_tb_top.sv
module adc_pace_ctrl_tb_top;
  localparam int CONV_CYC = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [15:0] period_cfg;
  logic [3:0]  rd_len_cfg;
  logic        adc_busy_n;
  logic [7:0]  adc_data;
  logic        adc_st, adc_cs_n, adc_rd_n, irq, pop;
  logic [7:0]  rd_data;
  logic        fifo_empty, fifo_full, overrun;
  logic [4:0]  fifo_level;
  logic [7:0]  drop_count;

  int n_chk = 0, n_bad = 0;
  int seq, conv_cnt, cyc;
  int st_viol, rd_viol, irq_bad, width_bad, stw_bad, ival_bad, n_strobe;
  int exp_rd_len, exp_period, last_rise, cs_w, st_w;
  bit chk_ival, prev_st, prev_cs_n;

  always #10 clk = ~clk;

  adc_pace_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .period_cfg(period_cfg),
    .rd_len_cfg(rd_len_cfg), .adc_busy_n(adc_busy_n), .adc_data(adc_data),
    .adc_st(adc_st), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .irq(irq),
    .pop(pop), .rd_data(rd_data), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .fifo_level(fifo_level), .overrun(overrun),
    .drop_count(drop_count)
  );

  function automatic logic [7:0] sval(input int k);
    return 8'(8'h30 + k * 7);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and port monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      seq = 0; conv_cnt = 0; cyc = 0; prev_st = 0; prev_cs_n = 1;
      st_viol = 0; rd_viol = 0; irq_bad = 0; width_bad = 0; stw_bad = 0;
      ival_bad = 0; n_strobe = 0; last_rise = -1; cs_w = 0; st_w = 0;
      adc_busy_n <= 1'b1;
      adc_data   <= 8'h00;
    end else begin
      cyc++;
      if (!adc_rd_n && (!adc_busy_n || adc_st)) rd_viol++;
      if (adc_cs_n != adc_rd_n) rd_viol++;
      if (irq != !adc_cs_n) irq_bad++;
      if (!adc_cs_n) cs_w++;
      if (adc_cs_n && !prev_cs_n) begin
        n_strobe++;
        if (cs_w != exp_rd_len) width_bad++;
        cs_w = 0;
      end
      if (adc_st) st_w++;
      if (adc_st && !prev_st) begin
        if (chk_ival && last_rise >= 0 && (cyc - last_rise) != exp_period) ival_bad++;
        last_rise = cyc;
      end
      if (conv_cnt != 0) begin
        conv_cnt--;
        if (conv_cnt == 0) begin
          adc_data <= sval(seq);
          seq++;
        end
      end
      if (prev_st && !adc_st) begin
        if (st_w != 2) stw_bad++;
        st_w = 0;
        if (conv_cnt != 0 || !adc_busy_n) st_viol++;
        conv_cnt = CONV_CYC;
      end
      adc_busy_n <= (conv_cnt == 0);
      prev_st   = adc_st;
      prev_cs_n = adc_cs_n;
    end
  end

  task automatic do_reset();
    enable = 0; pop = 0; period_cfg = 16'd40; rd_len_cfg = 4'd3;
    exp_rd_len = 3; exp_period = 40; chk_ival = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_until(input int n);
    enable = 1;
    while (seq < n) @(negedge clk);
    enable = 0;
    repeat (60) @(negedge clk);
  endtask

  task automatic drain_check(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      check(rd_data == sval(k), req, rd_data, sval(k));
      pop = 1;
      @(negedge clk);
      pop = 0;
    end
  endtask

  task automatic t_reset();
    enable = 0; pop = 0; period_cfg = 16'd40; rd_len_cfg = 4'd3;
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(!adc_st && adc_cs_n && adc_rd_n && !irq, "R1 strobes idle in reset", adc_st, 0);
    check(fifo_empty && !fifo_full && fifo_level == 0, "R1 fifo in reset", fifo_level, 0);
    rst_n = 1;
    @(negedge clk);
    check(!overrun && drop_count == 0, "R1 flags after reset", drop_count, 0);
    check(!adc_st && adc_cs_n, "R1 no activity while disabled", adc_st, 0);
  endtask

  task automatic t_basic();
    do_reset();
    chk_ival = 1;
    run_until(5);
    check(ival_bad == 0, "R2 start spacing", ival_bad, 0);
    check(stw_bad == 0, "R2 start width", stw_bad, 0);
    check(st_viol == 0, "R3 no start during conversion", st_viol, 0);
    check(rd_viol == 0, "R4 strobe legality", rd_viol, 0);
    check(width_bad == 0 && n_strobe == seq, "R4 strobe width", width_bad, 0);
    check(irq_bad == 0, "R6 irq tracks strobe", irq_bad, 0);
    check(!overrun, "R10 no overrun at slow rate", overrun, 0);
    check(fifo_level == 5'(seq), "R7 level", fifo_level, seq);
    drain_check(seq, "R5 data order");
    check(fifo_empty && fifo_level == 0, "R7 empty after drain", fifo_level, 0);
  endtask

  task automatic t_widths(input int len);
    do_reset();
    rd_len_cfg = 4'(len);
    exp_rd_len = (len == 0) ? 1 : len;
    run_until(3);
    check(width_bad == 0 && n_strobe == seq, "R4 programmed strobe width", width_bad, 0);
    check(irq_bad == 0, "R6 irq with other width", irq_bad, 0);
    drain_check(seq, "R5 data with other width");
  endtask

  task automatic t_overrun();
    do_reset();
    period_cfg = 16'd8;
    run_until(4);
    check(overrun, "R10 overrun set on skipped firing", overrun, 1);
    check(st_viol == 0, "R3 no start while busy at fast rate", st_viol, 0);
    check(rd_viol == 0, "R4 strobe legality at fast rate", rd_viol, 0);
    repeat (50) @(negedge clk);
    check(overrun, "R10 overrun sticky", overrun, 1);
    drain_check(seq, "R5 data at fast rate");
  endtask

  task automatic t_full();
    do_reset();
    period_cfg = 16'd30;
    run_until(20);
    check(fifo_full && fifo_level == 16, "R7 full at 16", fifo_level, 16);
    check(drop_count == 8'(seq - 16), "R8 drop count", drop_count, seq - 16);
    drain_check(16, "R8 kept samples are the oldest");
    check(fifo_empty, "R7 empty after drain", fifo_level, 0);
    pop = 1;
    repeat (3) @(negedge clk);
    pop = 0;
    @(negedge clk);
    check(fifo_empty && fifo_level == 0, "R9 pop on empty ignored", fifo_level, 0);
    check(drop_count == 8'(seq - 16), "R9 drop count unchanged", drop_count, seq - 16);
  endtask

  initial begin
    rst_n = 0; enable = 0; pop = 0; period_cfg = 16'd40; rd_len_cfg = 4'd3;
    exp_rd_len = 3; exp_period = 40; chk_ival = 0;
    t_reset();
    t_basic();
    t_widths(1);
    t_widths(6);
    t_widths(0);
    t_overrun();
    t_full();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule